// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a read-only byte cache that sits between a requester and a slower line-oriented memory. The total line count equals that of a direct-mapped cache of the same capacity, but the lines are split into two equal ways, a left way and a right way. Each way has its own tags, valid bits and tag comparator, and both ways are checked in parallel. Because each way holds half the lines, the set index is one bit narrower than in the direct-mapped layout and the tag is one bit wider. With a 20-bit address this gives a 9-bit tag, a 7-bit set index and a 4-bit byte offset.

A hit in either way returns the addressed byte. When both ways miss, the cache fetches the full 128-bit line from memory through a valid/ready request and installs it in one way of the set. Every response carries an outcome code that reports which way hit, or that the access was a double miss. A requester issues one read at a time and waits for its response before the next read is taken.

Top module: `c2w_read_cache`

## Requirements
- R1: The address splits into a byte offset in bits [3:0], a set index in bits [10:4] and a tag in bits [19:11]. The returned byte is line bits [8*offset+7 : 8*offset].
- R2: A hit in the left way returns outcome code 2'b01 with the byte. The response appears on the second rising edge after the request is accepted.
- R3: A miss in the left way together with a hit in the right way returns outcome code 2'b10 with the byte, with the same latency as R2.
- R4: A miss in both ways asserts mem_req_valid with mem_req_addr = address bits [19:4]. The request holds steady until mem_req_ready is seen. The response, with outcome 2'b11, is given on the edge that samples mem_rsp_valid.
- R5: A line installed by a fill hits on later reads of any byte in it, and a hit issues no memory request.
- R6: Two lines with the same set index and different tags can be resident at the same time, one per way. The two ways never both match one address.
- R7: A fill goes to the left way if it is invalid, otherwise to the right way if it is invalid. If both ways are valid, it goes to the least-recently-used way. Each set's recency bit is updated on every hit and every fill.
- R8: An entry that is not valid never hits. Reset clears every valid bit and every recency bit.
- R9: req_ready is high only when the cache is idle. Each accepted request produces exactly one resp_valid pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Cache can accept a request |
| req_addr | input | 20 | Byte address of the read |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_data | output | 8 | Byte read |
| resp_outcome | output | 2 | 01 left hit, 10 right hit, 11 double miss |
| mem_req_valid | output | 1 | Line fetch request |
| mem_req_ready | input | 1 | Memory accepts the fetch |
| mem_req_addr | output | 16 | Line address (address bits [19:4]) |
| mem_rsp_valid | input | 1 | Fetched line present |
| mem_rsp_data | input | 128 | Fetched line, byte k in bits [8k+7:8k] |

## Verification
A hit response is due two rising edges after the accepting edge. The bench drives the request at a falling edge and samples resp_valid exactly one and a half cycles later. It requires resp_valid to be low half a cycle after acceptance and high at that sample. A miss response is due on the edge that takes mem_rsp_valid, so the scoreboard monitor pops an expected item at whichever falling edge shows resp_valid. The driver waits for the queue to drain before the next read, and then compares the count of memory fetches and the last fetch address against what the access should have caused.

// File: rtl/c2w_pkg.sv
package c2w_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOOK  = 2'd1,
        ST_FETCH = 2'd2,
        ST_WAIT  = 2'd3
    } c2w_state_e;

    typedef enum logic [1:0] {
        OUT_NONE   = 2'b00,
        OUT_LEFT   = 2'b01,
        OUT_RIGHT  = 2'b10,
        OUT_DOUBLE = 2'b11
    } c2w_outcome_e;
endpackage

// File: rtl/c2w_way.sv
module c2w_way #(
    parameter int IDX_W  = 7,
    parameter int TAG_W  = 9,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_valid,
    output logic              rd_hit,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]   valid_q, valid_d;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] line_q [SETS];

    always_comb begin
        valid_d = valid_q;
        if (wr_en) valid_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            line_q[wr_idx] <= wr_line;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_hit   = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    assign rd_line  = line_q[rd_idx];

    // R5: a fill leaves the written entry valid with the new tag
    assert_fill_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)] && (tag_q[$past(wr_idx)] == $past(wr_tag)));
endmodule

// File: rtl/c2w_victim.sv
module c2w_victim (
    input  logic left_valid,
    input  logic right_valid,
    input  logic lru_way,
    output logic victim_way
);
    always_comb begin
        if (!left_valid)       victim_way = 1'b0;
        else if (!right_valid) victim_way = 1'b1;
        else                   victim_way = lru_way;
    end
endmodule

// File: rtl/c2w_read_cache.sv
module c2w_read_cache
    import c2w_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int IDX_W  = 7,
    parameter int OFF_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    output logic                    resp_valid,
    output logic [7:0]              resp_data,
    output logic [1:0]              resp_outcome,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic [ADDR_W-OFF_W-1:0] mem_req_addr,
    input  logic                    mem_rsp_valid,
    input  logic [(8<<OFF_W)-1:0]   mem_rsp_data
);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = 8 << OFF_W;
    localparam int SETS   = 1 << IDX_W;
    localparam int WAYS   = 2;

    typedef struct packed {
        c2w_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [SETS-1:0]   lru;
        logic              rv;
        logic [7:0]        rb;
        c2w_outcome_e      ro;
    } regs_t;

    regs_t q, d;

    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic [OFF_W-1:0]  cur_off;
    logic [OFF_W+2:0]  bit_off;
    logic [WAYS-1:0]   way_hit, way_valid, way_wr;
    logic [LINE_W-1:0] way_line [WAYS];
    logic              victim;

    assign cur_off = q.addr[OFF_W-1:0];
    assign cur_idx = q.addr[OFF_W +: IDX_W];
    assign cur_tag = q.addr[ADDR_W-1 -: TAG_W];
    assign bit_off = {cur_off, 3'b000};

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        c2w_way #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_way (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_idx   (cur_idx),
            .rd_tag   (cur_tag),
            .rd_valid (way_valid[w]),
            .rd_hit   (way_hit[w]),
            .rd_line  (way_line[w]),
            .wr_en    (way_wr[w]),
            .wr_idx   (cur_idx),
            .wr_tag   (cur_tag),
            .wr_line  (mem_rsp_data)
        );
    end

    c2w_victim u_victim (
        .left_valid  (way_valid[0]),
        .right_valid (way_valid[1]),
        .lru_way     (q.lru[cur_idx]),
        .victim_way  (victim)
    );

    always_comb begin
        d      = q;
        d.rv   = 1'b0;
        way_wr = '0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr = req_addr;
                    d.st   = ST_LOOK;
                end
            end
            ST_LOOK: begin
                if (way_hit[0]) begin
                    d.rv           = 1'b1;
                    d.rb           = way_line[0][bit_off +: 8];
                    d.ro           = OUT_LEFT;
                    d.lru[cur_idx] = 1'b1;
                    d.st           = ST_IDLE;
                end else if (way_hit[1]) begin
                    d.rv           = 1'b1;
                    d.rb           = way_line[1][bit_off +: 8];
                    d.ro           = OUT_RIGHT;
                    d.lru[cur_idx] = 1'b0;
                    d.st           = ST_IDLE;
                end else begin
                    d.st = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (mem_req_ready) d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    way_wr[victim] = 1'b1;
                    d.rv           = 1'b1;
                    d.rb           = mem_rsp_data[bit_off +: 8];
                    d.ro           = OUT_DOUBLE;
                    d.lru[cur_idx] = ~victim;
                    d.st           = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.addr <= '0;
            q.lru  <= '0;
            q.rv   <= 1'b0;
            q.rb   <= '0;
            q.ro   <= OUT_NONE;
        end else begin
            q <= d;
        end
    end

    assign req_ready     = (q.st == ST_IDLE);
    assign resp_valid    = q.rv;
    assign resp_data     = q.rb;
    assign resp_outcome  = q.ro;
    assign mem_req_valid = (q.st == ST_FETCH);
    assign mem_req_addr  = q.addr[ADDR_W-1:OFF_W];

    // R6: both ways matching the same address is an illegal state
    assert_single_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LOOK) |-> !(way_hit[0] && way_hit[1]));

    // R5: a hit must not start a memory fetch
    assert_hit_no_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_LOOK) && (way_hit != '0)) |=> !mem_req_valid);

    // R4: fetch request holds until accepted
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R9: response is a single-cycle pulse
    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R9: an accepted request makes the cache busy
    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2: every response carries a real outcome code
    assert_outcome_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_outcome != 2'b00));
endmodule

// File: tb/sim_c2w_read_cache.sv
module sim_c2w_read_cache;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid;
    logic         req_ready;
    logic [19:0]  req_addr;
    logic         resp_valid;
    logic [7:0]   resp_data;
    logic [1:0]   resp_outcome;
    logic         mem_req_valid;
    logic         mem_req_ready;
    logic [15:0]  mem_req_addr;
    logic         mem_rsp_valid;
    logic [127:0] mem_rsp_data;

    int checks = 0;
    int fails  = 0;
    int fetches = 0;
    logic [15:0] last_fetch = '0;
    logic [9:0]  expq [$];
    bit done = 0;

    always #5 clk = ~clk;

    c2w_read_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .resp_valid(resp_valid), .resp_data(resp_data), .resp_outcome(resp_outcome),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [7:0] mem_byte(logic [15:0] la, int k);
        return la[7:0] + la[15:8] + 8'(k * 37) + 8'd3;
    endfunction

    function automatic logic [127:0] mem_line(logic [15:0] la);
        logic [127:0] l;
        for (int k = 0; k < 16; k++) l[8*k +: 8] = mem_byte(la, k);
        return l;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory model: delays ready, then returns the line
    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                repeat (2) @(negedge clk);
                mem_req_ready = 1'b1;
                last_fetch = mem_req_addr;
                fetches++;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat (3) @(negedge clk);
                mem_rsp_data  = mem_line(last_fetch);
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    // monitor: pops expected items as responses appear
    always @(negedge clk) begin
        if (resp_valid) begin
            if (expq.size() == 0) begin
                chk(0, "R9", "unexpected response", 1, 0);
            end else begin
                logic [9:0] e;
                e = expq.pop_front();
                chk(resp_outcome == e[9:8], "R2/R3/R4/R7", "outcome", resp_outcome, e[9:8]);
                chk(resp_data == e[7:0], "R1", "data byte", resp_data, e[7:0]);
            end
        end
    end

    // driver: outc 1 left hit, 2 right hit, 3 double miss
    task automatic rd(logic [19:0] a, logic [1:0] outc);
        int f0;
        f0 = fetches;
        while (!req_ready) @(negedge clk);
        expq.push_back({outc, mem_byte(a[19:4], int'(a[3:0]))});
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!resp_valid && !req_ready, "R9", "busy after accept", req_ready, 0);
        @(negedge clk);
        if (outc != 2'b11)
            chk(resp_valid, "R2", "hit latency", resp_valid, 1);
        while (expq.size() != 0) @(negedge clk);
        @(negedge clk);
        if (outc == 2'b11) begin
            chk(fetches == f0 + 1, "R4", "fetch count", fetches - f0, 1);
            chk(last_fetch == a[19:4], "R4", "fetch line address", last_fetch, a[19:4]);
        end else begin
            chk(fetches == f0, "R5", "hit issued fetch", fetches - f0, 0);
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            chk(0, "R9", "watchdog expired", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R9", "reset ready", req_ready, 1);
        chk(!resp_valid, "R8", "reset resp_valid", resp_valid, 0);
        chk(!mem_req_valid, "R8", "reset mem_req_valid", mem_req_valid, 0);

        // set 0x34: tags 0x24 (0x1234), 0x44 (0x2234), 0x64 (0x3234)
        rd(20'h12345, 2'b11); // R8 empty set misses, R7 fills left
        rd(20'h12340, 2'b01); // R5 same line hits, R2 left
        rd(20'h22343, 2'b11); // R7 fills invalid right way
        rd(20'h12345, 2'b01); // R6 both lines resident
        rd(20'h22340, 2'b10); // R3 right hit; left now least recent
        rd(20'h32340, 2'b11); // R7 evicts least recent (left)
        rd(20'h22341, 2'b10); // R6 right survives
        rd(20'h12345, 2'b11); // R7 evicted line misses, fills left
        rd(20'h3234F, 2'b11); // R7 right was least recent, evicted
        rd(20'h1234A, 2'b01); // R1 other offset, left hit
        rd(20'h3234F, 2'b10); // R3 right hit on refilled line
        rd(20'h00010, 2'b11); // R1 other set
        rd(20'h0001F, 2'b01); // R1 last byte of line

        // R8 reset clears valid bits
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(20'h12345, 2'b11);
        rd(20'h22345, 2'b11); // R8 recency cleared: fills invalid right
        rd(20'h12346, 2'b01);
        rd(20'h22346, 2'b10);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule